// File: doc/BRIEF.md
# Inverter Leg Interlock and Fault Latch

This block sits between a PWM controller and the gate drivers of a three-phase bridge with a brake switch. Each phase has an upper and a lower command, and the brake has one command. All commands are active low. The block turns these commands into active-high gate enables. It prevents both switches of a phase from conducting at the same time, and it holds a shoot-through fault until the commands of that phase are re-issued in a clean way. Per-switch short-circuit comparators cut the gate of the switch that tripped. That cut lasts only until the next on command for that switch. A current-limit comparator raises a warning that clears on the next on command of any phase switch.

All command and comparator inputs pass through a two-flop synchronizer. Every latch and clear decision is then made on the system clock. The fault and warning outputs are active low, in the manner of open-drain lines.

Top module: `leg_guard`

## Requirements
- R1: While reset is asserted, every gate output is 0 and both `fault_n` and `warn_n` are 1.
- R2: A command input at 0 means "switch on". With `enable` high and no fault on that switch, a command sampled at clock edge k drives its gate output from edge k+1 onward.
- R3: When the synchronized upper and lower commands of a phase are both on, both gates of that phase are 0 and `fault_n` is 0 in that same cycle.
- R4: After an overlap, the phase stays latched once the commands are released. While latched, `fault_n` stays 0 and both gates of that phase stay 0.
- R5: A latched phase clears only once both its upper and its lower command have each made a new off-to-on transition. The clear takes effect on the clock edge after the later of the two transitions is seen. A single transition does not clear it.
- R6: A synchronized short-circuit input at 1 on a switch that is on latches a shutdown of that switch alone. The other switches keep following their commands, and `fault_n` reads 0 while any shutdown is latched.
- R7: A short-circuit shutdown stays latched while the command stays on. It releases on the clock edge after that switch's next off-to-on transition is seen.
- R8: A synchronized `cur_over` at 1 drives `warn_n` to 0 from the next edge. It returns to 1 on the edge after any phase switch makes an off-to-on transition, once `cur_over` is 0.
- R9: The brake gate follows the inverted brake command when `enable` is high. It is unaffected by interlock and short-circuit inputs.
- R10: With `enable` at 0, every gate output is 0 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global gate enable, active high |
| hi_cmd_n | input | NPH | Upper switch commands, 0 = on |
| lo_cmd_n | input | NPH | Lower switch commands, 0 = on |
| brk_cmd_n | input | 1 | Brake command, 0 = on |
| hi_sc | input | NPH | Upper short-circuit comparators, 1 = tripped |
| lo_sc | input | NPH | Lower short-circuit comparators, 1 = tripped |
| cur_over | input | 1 | Current-limit comparator, 1 = over limit |
| gate_hi | output | NPH | Upper gate enables |
| gate_lo | output | NPH | Lower gate enables |
| gate_brk | output | 1 | Brake gate enable |
| fault_n | output | 1 | Shared shoot-through / short-circuit fault, 0 = asserted |
| warn_n | output | 1 | Current-limit warning, 0 = asserted |

## Verification
The in-RTL properties are checked on every cycle. They cover the following:
- overlap suppression;
- gates held off and the fault line low while an interlock or short-circuit latch is set;
- warning assertion after an over-limit sample;
- the enable and brake pass-through.

What the per-cycle checks cannot express is the clear rules. These are the later-of-two-edges release of the interlock, the per-switch re-arm of the short-circuit cut, and the warning reset on a new command. They depend on the ordering of command edges over many cycles. The bench shows them through directed sequences and a randomized run, both compared against its behavioural model.

// File: rtl/leg_guard.sv
module leg_guard #(
  parameter int NPH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic [NPH-1:0] hi_cmd_n,
  input  logic [NPH-1:0] lo_cmd_n,
  input  logic           brk_cmd_n,
  input  logic [NPH-1:0] hi_sc,
  input  logic [NPH-1:0] lo_sc,
  input  logic           cur_over,
  output logic [NPH-1:0] gate_hi,
  output logic [NPH-1:0] gate_lo,
  output logic           gate_brk,
  output logic           fault_n,
  output logic           warn_n
);
  localparam int NSW = 2 * NPH;

  logic [NSW:0]   cmd_a, cmd_b, on_prev;
  logic [NSW-1:0] sc_a, sc_b, sc_lat;
  logic           cur_a, cur_b, warn_lat;
  logic [NPH-1:0] il_lat, seen_hi, seen_lo;

  logic [NSW:0]   on, rise;
  logic [NPH-1:0] on_hi, on_lo, ovl;

  assign on    = ~cmd_b;
  assign rise  = on & ~on_prev;
  assign on_hi = on[NPH-1:0];
  assign on_lo = on[NSW-1:NPH];
  assign ovl   = on_hi & on_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_a   <= '1;
      cmd_b   <= '1;
      on_prev <= '0;
      sc_a    <= '0;
      sc_b    <= '0;
      cur_a   <= 1'b0;
      cur_b   <= 1'b0;
    end else begin
      cmd_a   <= {brk_cmd_n, lo_cmd_n, hi_cmd_n};
      cmd_b   <= cmd_a;
      on_prev <= on;
      sc_a    <= {lo_sc, hi_sc};
      sc_b    <= sc_a;
      cur_a   <= cur_over;
      cur_b   <= cur_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      il_lat  <= '0;
      seen_hi <= '0;
      seen_lo <= '0;
    end else begin
      for (int p = 0; p < NPH; p++) begin
        if (ovl[p]) begin
          il_lat[p]  <= 1'b1;
          seen_hi[p] <= 1'b0;
          seen_lo[p] <= 1'b0;
        end else if (il_lat[p]) begin
          if ((seen_hi[p] | rise[p]) & (seen_lo[p] | rise[NPH+p])) begin
            il_lat[p]  <= 1'b0;
            seen_hi[p] <= 1'b0;
            seen_lo[p] <= 1'b0;
          end else begin
            seen_hi[p] <= seen_hi[p] | rise[p];
            seen_lo[p] <= seen_lo[p] | rise[NPH+p];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_lat   <= '0;
      warn_lat <= 1'b0;
    end else begin
      sc_lat   <= (sc_b & on[NSW-1:0]) | (sc_lat & ~rise[NSW-1:0]);
      warn_lat <= cur_b | (warn_lat & ~(|rise[NSW-1:0]));
    end
  end

  assign gate_hi  = {NPH{enable}} & on_hi & ~ovl & ~il_lat & ~sc_lat[NPH-1:0];
  assign gate_lo  = {NPH{enable}} & on_lo & ~ovl & ~il_lat & ~sc_lat[NSW-1:NPH];
  assign gate_brk = enable & on[NSW];
  assign fault_n  = ~((|ovl) | (|il_lat) | (|sc_lat));
  assign warn_n   = ~warn_lat;

  // R3
  ovl_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl != '0) |-> (!fault_n && ((ovl & (gate_hi | gate_lo)) == '0)));

  // R4
  il_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (il_lat != '0) |-> (!fault_n && ((il_lat & (gate_hi | gate_lo)) == '0)));

  // R6
  sc_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_lat != '0) |-> (!fault_n && ((sc_lat & {gate_lo, gate_hi}) == '0)));

  // R8
  warn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_b |=> !warn_n);

  // R10
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (gate_hi == '0 && gate_lo == '0 && !gate_brk));

  // R9
  brake_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !cmd_b[NSW]) |-> gate_brk);
endmodule

// File: tb/leg_guard_tb.sv
module leg_guard_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic [2:0] hi_n = 3'b111, lo_n = 3'b111, hsc = 3'b000, lsc = 3'b000;
  logic brk_n = 1'b1, cur = 1'b0;
  logic [2:0] g_hi, g_lo;
  logic g_brk, flt_n, wrn_n;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  leg_guard #(.NPH(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(en),
    .hi_cmd_n(hi_n), .lo_cmd_n(lo_n), .brk_cmd_n(brk_n),
    .hi_sc(hsc), .lo_sc(lsc), .cur_over(cur),
    .gate_hi(g_hi), .gate_lo(g_lo), .gate_brk(g_brk),
    .fault_n(flt_n), .warn_n(wrn_n)
  );

  // behavioural model: index 0..2 upper, 3..5 lower, 6 brake; "1" means on
  bit m_q1 [7], m_q2 [7], m_old [7];
  bit m_t1 [6], m_t2 [6], m_cut [6];
  bit m_lock [3], m_gotu [3], m_gotl [3];
  bit m_w1, m_w2, m_warn;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 7; i++) begin m_q1[i] = 0; m_q2[i] = 0; m_old[i] = 0; end
      for (int i = 0; i < 6; i++) begin m_t1[i] = 0; m_t2[i] = 0; m_cut[i] = 0; end
      for (int i = 0; i < 3; i++) begin m_lock[i] = 0; m_gotu[i] = 0; m_gotl[i] = 0; end
      m_w1 = 0; m_w2 = 0; m_warn = 0;
    end else begin
      bit edg [7];
      bit anyedge;
      anyedge = 0;
      for (int i = 0; i < 7; i++) edg[i] = m_q2[i] && !m_old[i];
      for (int i = 0; i < 6; i++) anyedge |= edg[i];
      for (int p = 0; p < 3; p++) begin
        if (m_q2[p] && m_q2[p+3]) begin
          m_lock[p] = 1; m_gotu[p] = 0; m_gotl[p] = 0;
        end else if (m_lock[p]) begin
          m_gotu[p] |= edg[p];
          m_gotl[p] |= edg[p+3];
          if (m_gotu[p] && m_gotl[p]) begin m_lock[p] = 0; m_gotu[p] = 0; m_gotl[p] = 0; end
        end
      end
      for (int i = 0; i < 6; i++)
        m_cut[i] = (m_t2[i] && m_q2[i]) || (m_cut[i] && !edg[i]);
      m_warn = m_w2 || (m_warn && !anyedge);
      for (int i = 0; i < 7; i++) m_old[i] = m_q2[i];
      m_q2 = m_q1; m_t2 = m_t1; m_w2 = m_w1;
      for (int i = 0; i < 3; i++) begin
        m_q1[i] = !hi_n[i]; m_q1[i+3] = !lo_n[i];
        m_t1[i] = hsc[i]; m_t1[i+3] = lsc[i];
      end
      m_q1[6] = !brk_n; m_w1 = cur;
    end
  end

  task automatic chk(string req, string what, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%b exp=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      logic [2:0] e_hi, e_lo;
      logic e_flt;
      e_flt = 0;
      for (int p = 0; p < 3; p++) begin
        bit ov;
        ov = m_q2[p] && m_q2[p+3];
        e_hi[p] = en && m_q2[p] && !ov && !m_lock[p] && !m_cut[p];
        e_lo[p] = en && m_q2[p+3] && !ov && !m_lock[p] && !m_cut[p+3];
        if (ov || m_lock[p] || m_cut[p] || m_cut[p+3]) e_flt = 1;
      end
      chk("R2", "gate_hi", {1'b0, g_hi}, {1'b0, e_hi});
      chk("R3", "gate_lo", {1'b0, g_lo}, {1'b0, e_lo});
      chk("R9", "gate_brk", {3'b0, g_brk}, {3'b0, en && m_q2[6]});
      chk("R6", "fault_n", {3'b0, flt_n}, {3'b0, !e_flt});
      chk("R8", "warn_n", {3'b0, wrn_n}, {3'b0, !m_warn});
    end
    if (cyc > 100000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    tick(3);
    // R1
    chk("R1", "reset gates", {g_brk, g_hi}, 4'b0000);
    chk("R1", "reset lo gates", {1'b0, g_lo}, 4'b0000);
    chk("R1", "reset flags", {2'b0, flt_n, wrn_n}, 4'b0011);
    rst_n = 1'b1;
    tick(3);

    // R2 latency: on after second edge
    hi_n[0] = 1'b0;
    tick(1); chk("R2", "gate_hi0 early", {3'b0, g_hi[0]}, 4'b0000);
    tick(1); chk("R2", "gate_hi0 on", {3'b0, g_hi[0]}, 4'b0001);
    hi_n[0] = 1'b1; tick(3);

    // R3 / R4 / R5 interlock on phase 1
    hi_n[1] = 1'b0; lo_n[1] = 1'b0;
    tick(2);
    chk("R3", "overlap gates+fault", {g_hi[1], g_lo[1], flt_n, 1'b0}, 4'b0000);
    hi_n[1] = 1'b1; lo_n[1] = 1'b1; tick(4);
    chk("R4", "latched fault", {3'b0, flt_n}, 4'b0000);
    hi_n[1] = 1'b0; tick(4);
    chk("R5", "one edge no clear", {2'b0, g_hi[1], flt_n}, 4'b0000);
    hi_n[1] = 1'b1; tick(3);
    lo_n[1] = 1'b0; tick(2);
    chk("R5", "later edge seen", {3'b0, flt_n}, 4'b0000);
    tick(1);
    chk("R5", "cleared", {2'b0, g_lo[1], flt_n}, 4'b0011);
    lo_n[1] = 1'b1; tick(3);

    // R6 / R7 short circuit on upper phase 2
    hi_n[2] = 1'b0; lo_n[0] = 1'b0; tick(3);
    hsc[2] = 1'b1; tick(3);
    chk("R6", "sc cut", {1'b0, g_hi[2], g_lo[0], flt_n}, 4'b0010);
    hsc[2] = 1'b0; tick(3);
    chk("R7", "sc held", {2'b0, g_hi[2], flt_n}, 4'b0000);
    hi_n[2] = 1'b1; tick(3);
    hi_n[2] = 1'b0; tick(2);
    chk("R7", "sc before release", {3'b0, g_hi[2]}, 4'b0000);
    tick(1);
    chk("R7", "sc released", {2'b0, g_hi[2], flt_n}, 4'b0011);
    hi_n[2] = 1'b1; lo_n[0] = 1'b1; tick(3);

    // R8 warning
    cur = 1'b1; tick(1); cur = 1'b0; tick(2);
    chk("R8", "warn set", {3'b0, wrn_n}, 4'b0000);
    tick(3);
    chk("R8", "warn held", {3'b0, wrn_n}, 4'b0000);
    lo_n[2] = 1'b0; tick(2);
    chk("R8", "warn edge seen", {3'b0, wrn_n}, 4'b0000);
    tick(1);
    chk("R8", "warn cleared", {3'b0, wrn_n}, 4'b0001);
    lo_n[2] = 1'b1; tick(3);

    // R9 brake ignores comparators
    brk_n = 1'b0; hsc = 3'b111; lsc = 3'b111; tick(4);
    chk("R9", "brake on", {3'b0, g_brk}, 4'b0001);
    hsc = 3'b000; lsc = 3'b000; tick(3);

    // R10 enable
    hi_n[0] = 1'b0; en = 1'b0; tick(3);
    chk("R10", "disabled", {2'b0, g_hi[0], g_brk}, 4'b0000);
    en = 1'b1; #0;
    chk("R10", "re-enabled", {2'b0, g_hi[0], g_brk}, 4'b0011);
    hi_n[0] = 1'b1; brk_n = 1'b1; tick(3);

    // mixed stimulus against the model
    for (int k = 0; k < 600; k++) begin
      hi_n  = 3'($urandom());
      lo_n  = 3'($urandom()) | ((k % 5 != 0) ? ~hi_n : 3'b000);
      brk_n = 1'($urandom());
      hsc   = ($urandom() % 9 == 0) ? 3'($urandom()) : 3'b000;
      lsc   = ($urandom() % 9 == 0) ? 3'($urandom()) : 3'b000;
      cur   = ($urandom() % 11 == 0);
      en    = ($urandom() % 13 != 0);
      tick(1 + ($urandom() % 3));
    end
    tick(2);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule